// File: doc/BRIEF.md
# Snooze Entry and Wake-Up Sequencer

This block sequences a synchronous SRAM into and out of a low-power snooze state. An asynchronous, active-high snooze request is first brought into the clock domain. The block then walks through a fixed-length entry phase, holds the snoozing state while the request stays high, and walks through a fixed-length exit phase. After that it holds a deselected recovery window before it hands the access logic back to normal operation. Stored data is never touched; the block only gates the access path.

Its outputs go to the neighbouring access logic. `in_gate` tells that logic to ignore every synchronous input. `xfer_kill` marks any access in flight as invalid when entry starts. `snoozing` reports the snoozing state. `rule_break` pulses when the select pins or address strobes are active at a moment the protocol forbids.

Top module: `snooze_seq`

## Requirements
- R1: While reset is held, and right after it is released with the request low, `snoozing`, `in_gate`, `xfer_kill` and `rule_break` are all 0.
- R2: The request passes through a two-flop synchronizer, so a rise of `snz_req_a` between edges leaves `in_gate` at 0 for the next two rising edges. `in_gate` is 1 after the third edge, and `xfer_kill` is 1 for exactly that one cycle.
- R3: Entry lasts two cycles: `snoozing` goes to 1 two edges after `in_gate` rises.
- R4: While snoozing and while the request stays high, `snoozing` stays 1 and the select pins and strobes have no effect: no `rule_break` and no wake-up.
- R5: After the request falls, `snoozing` drops at the third edge. Exit then lasts two cycles and recovery two more. `in_gate` returns to 0 at the seventh edge after the fall.
- R6: Once entry has started it always completes into the snoozing state, even if the request falls during entry. The full exit and recovery sequence then follows.
- R7: The device counts as engaged when it is fully selected (`sel1_n`=0, `sel2`=1, `sel3_n`=0) or when either strobe (`pstb_n`, `cstb_n`) is 0. If it is engaged in the cycle where the synchronized request is first seen high while awake, `rule_break` is 1 for one cycle, starting at the edge where `in_gate` rises.
- R8: If the device is engaged during the exit or recovery cycles, `rule_break` is 1 in the cycle after that cycle.
- R9: While awake with the request low, engaging the device never raises `rule_break` and never raises `in_gate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| snz_req_a | input | 1 | Asynchronous snooze request, active high |
| sel1_n | input | 1 | Select 1, active low |
| sel2 | input | 1 | Select 2, active high |
| sel3_n | input | 1 | Select 3, active low |
| pstb_n | input | 1 | Processor-side address strobe, active low |
| cstb_n | input | 1 | Controller-side address strobe, active low |
| snoozing | output | 1 | High while in the snoozing state |
| in_gate | output | 1 | High whenever not fully awake; access logic ignores its inputs |
| xfer_kill | output | 1 | One-cycle pulse marking an in-flight access invalid at entry start |
| rule_break | output | 1 | One-cycle pulse on a select/strobe protocol violation |

## Verification
The bench counts edges from a request change, because a synchronizer one stage short or long shifts every output by a cycle. An extra stage would make `in_gate` rise one edge late, and a missing one would make it rise one edge early. One scenario drops the request in the middle of entry: a design that aborts the entry would never show `snoozing`, and would release `in_gate` too early. Strobes are driven while snoozing and while awake without a request; a design with a too-wide violation window would pulse `rule_break` there. A strobe is also driven in one recovery cycle, and a design that skipped recovery or counted it short would miss that pulse or drop `in_gate` early.

// File: rtl/snz_pkg.sv
package snz_pkg;
   typedef enum logic [2:0] {
      SNZ_AWAKE    = 3'd0,
      SNZ_ENTERING = 3'd1,
      SNZ_ASLEEP   = 3'd2,
      SNZ_EXITING  = 3'd3,
      SNZ_RECOVERY = 3'd4
   } snz_state_e;
endpackage

// File: rtl/snz_sync.sv
module snz_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("snz_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         logic d_in;
         if (i == 0) begin : g_first
            assign d_in = async_in;
         end else begin : g_next
            assign d_in = chain[i-1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= d_in;
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/snz_fsm.sv
module snz_fsm
   import snz_pkg::*;
#(
   parameter int ENTRY_CYCLES    = 2,
   parameter int EXIT_CYCLES     = 2,
   parameter int RECOVERY_CYCLES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_s,
   output snz_state_e state_o,
   output logic       kill_o
);
   localparam int MAX_LEN = (ENTRY_CYCLES > EXIT_CYCLES)
                            ? ((ENTRY_CYCLES > RECOVERY_CYCLES) ? ENTRY_CYCLES : RECOVERY_CYCLES)
                            : ((EXIT_CYCLES > RECOVERY_CYCLES) ? EXIT_CYCLES : RECOVERY_CYCLES);
   localparam int CNT_W = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);
   localparam logic [CNT_W-1:0] ENT_LOAD = CNT_W'(ENTRY_CYCLES - 1);
   localparam logic [CNT_W-1:0] EXT_LOAD = CNT_W'(EXIT_CYCLES - 1);
   localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(RECOVERY_CYCLES - 1);

   generate
      if (ENTRY_CYCLES < 1 || EXIT_CYCLES < 1 || RECOVERY_CYCLES < 1) begin : g_bad_len
         $error("snz_fsm: every phase length must be at least 1");
      end
   endgenerate

   snz_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             kill_q, kill_d;
   logic             cnt_done;

   assign cnt_done = (cnt_q == '0);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      kill_d  = 1'b0;
      unique case (state_q)
         SNZ_AWAKE: begin
            if (req_s) begin
               state_d = SNZ_ENTERING;
               cnt_d   = ENT_LOAD;
               kill_d  = 1'b1;
            end
         end
         SNZ_ENTERING: begin
            if (cnt_done) state_d = SNZ_ASLEEP;
            else          cnt_d   = cnt_q - 1'b1;
         end
         SNZ_ASLEEP: begin
            if (!req_s) begin
               state_d = SNZ_EXITING;
               cnt_d   = EXT_LOAD;
            end
         end
         SNZ_EXITING: begin
            if (cnt_done) begin
               state_d = SNZ_RECOVERY;
               cnt_d   = REC_LOAD;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         SNZ_RECOVERY: begin
            if (cnt_done) state_d = SNZ_AWAKE;
            else          cnt_d   = cnt_q - 1'b1;
         end
         default: begin
            state_d = SNZ_AWAKE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SNZ_AWAKE;
         cnt_q   <= '0;
         kill_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         kill_q  <= kill_d;
      end
   end

   assign state_o = state_q;
   assign kill_o  = kill_q;

   // Independent dwell counter: cycles spent in the current state.
   int unsigned dwell;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  dwell <= 1;
      else if (state_d != state_q) dwell <= 1;
      else if (dwell != 32'hFFFF_FFFF) dwell <= dwell + 1;
   end

   AST_ENTRY_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == SNZ_ENTERING && state_q != SNZ_ENTERING)
         |-> $past(dwell) == ENTRY_CYCLES); // R3
   AST_EXIT_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == SNZ_EXITING && state_q != SNZ_EXITING)
         |-> $past(dwell) == EXIT_CYCLES); // R5
   AST_RECOVERY_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == SNZ_RECOVERY && state_q != SNZ_RECOVERY)
         |-> $past(dwell) == RECOVERY_CYCLES); // R5
   AST_ENTER_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == SNZ_AWAKE && state_q != SNZ_AWAKE)
         |-> state_q == SNZ_ENTERING); // R2
   AST_WAKE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) != SNZ_AWAKE && state_q == SNZ_AWAKE)
         |-> $past(state_q) == SNZ_RECOVERY); // R5
   AST_ENTRY_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == SNZ_ENTERING && state_q != SNZ_ENTERING)
         |-> state_q == SNZ_ASLEEP); // R6
endmodule

// File: rtl/snz_guard.sv
module snz_guard
   import snz_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  snz_state_e state,
   input  logic       req_s,
   input  logic       sel1_n,
   input  logic       sel2,
   input  logic       sel3_n,
   input  logic       pstb_n,
   input  logic       cstb_n,
   output logic       flag_o
);
   logic selected, engaged, window;

   assign selected = !sel1_n && sel2 && !sel3_n;
   assign engaged  = selected || !pstb_n || !cstb_n;
   assign window   = (state == SNZ_AWAKE && req_s)
                   || state == SNZ_EXITING
                   || state == SNZ_RECOVERY;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= 1'b0;
      else        flag_o <= window && engaged;
   end
endmodule

// File: rtl/snooze_seq.sv
module snooze_seq
   import snz_pkg::*;
#(
   parameter int SYNC_STAGES     = 2,
   parameter int ENTRY_CYCLES    = 2,
   parameter int EXIT_CYCLES     = 2,
   parameter int RECOVERY_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic snz_req_a,
   input  logic sel1_n,
   input  logic sel2,
   input  logic sel3_n,
   input  logic pstb_n,
   input  logic cstb_n,
   output logic snoozing,
   output logic in_gate,
   output logic xfer_kill,
   output logic rule_break
);
   logic       req_s;
   snz_state_e state;

   snz_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (snz_req_a),
      .sync_out (req_s)
   );

   snz_fsm #(
      .ENTRY_CYCLES    (ENTRY_CYCLES),
      .EXIT_CYCLES     (EXIT_CYCLES),
      .RECOVERY_CYCLES (RECOVERY_CYCLES)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_s   (req_s),
      .state_o (state),
      .kill_o  (xfer_kill)
   );

   snz_guard u_guard (
      .clk    (clk),
      .rst_n  (rst_n),
      .state  (state),
      .req_s  (req_s),
      .sel1_n (sel1_n),
      .sel2   (sel2),
      .sel3_n (sel3_n),
      .pstb_n (pstb_n),
      .cstb_n (cstb_n),
      .flag_o (rule_break)
   );

   assign snoozing = (state == SNZ_ASLEEP);
   assign in_gate  = (state != SNZ_AWAKE);

   AST_SNOOZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      snoozing |-> !rule_break); // R4
   AST_KILL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_kill |-> (in_gate && !snoozing)); // R2
   AST_KILL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_kill |=> !xfer_kill); // R2
endmodule

// File: tb/tb_snooze_seq.sv
module tb_snooze_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic snz_req_a = 1'b0;
   logic sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
   logic pstb_n = 1'b1, cstb_n = 1'b1;
   logic snoozing, in_gate, xfer_kill, rule_break;
   int   checks = 0;
   int   errors = 0;

   always #4 clk = ~clk;

   snooze_seq dut (
      .clk(clk), .rst_n(rst_n), .snz_req_a(snz_req_a),
      .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
      .pstb_n(pstb_n), .cstb_n(cstb_n),
      .snoozing(snoozing), .in_gate(in_gate),
      .xfer_kill(xfer_kill), .rule_break(rule_break)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic idle_pins();
      sel1_n = 1'b1; sel2 = 1'b0; sel3_n = 1'b1;
      pstb_n = 1'b1; cstb_n = 1'b1;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1", "snoozing in reset", snoozing, 1'b0);
      chk("R1", "in_gate in reset", in_gate, 1'b0);
      chk("R1", "xfer_kill in reset", xfer_kill, 1'b0);
      chk("R1", "rule_break in reset", rule_break, 1'b0);
      rst_n = 1'b1;
      tick();
      chk("R1", "in_gate after reset", in_gate, 1'b0);
      chk("R1", "snoozing after reset", snoozing, 1'b0);
   endtask

   task automatic t_awake_engaged();
      sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R9", "rule_break selected awake", rule_break, 1'b0);
         chk("R9", "in_gate selected awake", in_gate, 1'b0);
      end
      idle_pins();
      pstb_n = 1'b0; cstb_n = 1'b0;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R9", "rule_break strobes awake", rule_break, 1'b0);
      end
      idle_pins();
      tick();
   endtask

   task automatic t_full_cycle();
      sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
      snz_req_a = 1'b1;
      tick();
      chk("R2", "in_gate edge1", in_gate, 1'b0);
      tick();
      chk("R2", "in_gate edge2", in_gate, 1'b0);
      chk("R7", "rule_break edge2", rule_break, 1'b0);
      tick();
      chk("R2", "in_gate edge3", in_gate, 1'b1);
      chk("R2", "xfer_kill edge3", xfer_kill, 1'b1);
      chk("R7", "rule_break edge3", rule_break, 1'b1);
      chk("R3", "snoozing edge3", snoozing, 1'b0);
      idle_pins();
      tick();
      chk("R2", "xfer_kill edge4", xfer_kill, 1'b0);
      chk("R7", "rule_break edge4", rule_break, 1'b0);
      chk("R3", "snoozing edge4", snoozing, 1'b0);
      tick();
      chk("R3", "snoozing edge5", snoozing, 1'b1);
      sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0; pstb_n = 1'b0; cstb_n = 1'b0;
      for (int i = 0; i < 6; i++) begin
         tick();
         chk("R4", "snoozing held", snoozing, 1'b1);
         chk("R4", "rule_break while snoozing", rule_break, 1'b0);
      end
      idle_pins();
      snz_req_a = 1'b0;
      tick();
      chk("R5", "snoozing fall edge1", snoozing, 1'b1);
      tick();
      chk("R5", "snoozing fall edge2", snoozing, 1'b1);
      tick();
      chk("R5", "snoozing fall edge3", snoozing, 1'b0);
      chk("R5", "in_gate fall edge3", in_gate, 1'b1);
      tick();
      chk("R5", "in_gate fall edge4", in_gate, 1'b1);
      tick();
      chk("R5", "in_gate fall edge5", in_gate, 1'b1);
      cstb_n = 1'b0;
      tick();
      chk("R8", "rule_break recovery", rule_break, 1'b1);
      chk("R5", "in_gate fall edge6", in_gate, 1'b1);
      cstb_n = 1'b1;
      tick();
      chk("R5", "in_gate fall edge7", in_gate, 1'b0);
      chk("R8", "rule_break after recovery", rule_break, 1'b0);
      tick();
   endtask

   task automatic t_exit_violation();
      snz_req_a = 1'b1;
      for (int i = 0; i < 5; i++) tick();
      chk("R3", "snoozing before exit test", snoozing, 1'b1);
      snz_req_a = 1'b0;
      tick(); tick(); tick();
      chk("R5", "exiting state", snoozing, 1'b0);
      sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
      tick();
      chk("R8", "rule_break during exit", rule_break, 1'b1);
      idle_pins();
      tick(); tick(); tick();
      chk("R5", "awake after exit test", in_gate, 1'b0);
   endtask

   task automatic t_drop_during_entry();
      snz_req_a = 1'b1;
      tick(); tick(); tick();
      chk("R6", "in_gate entry started", in_gate, 1'b1);
      snz_req_a = 1'b0;
      tick();
      chk("R6", "snoozing edge4", snoozing, 1'b0);
      tick();
      chk("R6", "snoozing edge5", snoozing, 1'b1);
      tick();
      chk("R6", "snoozing edge6", snoozing, 1'b0);
      chk("R6", "in_gate edge6", in_gate, 1'b1);
      tick(); tick(); tick();
      chk("R6", "in_gate edge9", in_gate, 1'b1);
      tick();
      chk("R6", "in_gate edge10", in_gate, 1'b0);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_awake_engaged();
      t_full_cycle();
      t_exit_violation();
      t_drop_during_entry();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule